// File: doc/BRIEF.md
# Warp Lane Mask Sequencer for Divergent Control Flow

This block tracks which of the 32 lanes of a warp are enabled while the warp walks through data-dependent branches and loops. All lanes share one instruction stream, so when lanes disagree on a branch condition the warp runs both sides one after the other. Lanes that do not belong to the side being run are switched off. The instruction sequencer sends one command per cycle, and the block keeps the enable mask that the lane datapath uses.

A divergent branch saves the enclosing mask together with the lanes still owed the other side. It then enables only the lanes whose condition is true. An else command switches to the owed lanes, and a join command puts the enclosing mask back. A loop test drops the lanes that leave the loop and keeps going with the rest. When the last lane leaves, the mask that was active before the loop first diverged comes back. A small stack of saved frames makes nesting possible. Pushing onto a full stack, or popping from an empty one, raises a one-cycle error flag and leaves everything else unchanged.

Top module: `simt_div_mask`

## Requirements
- R1: While rst is high, and in the first cycle after it, active_mask is all ones, ovf_err and udf_err are 0, and the stack is empty. A join issued next raises udf_err.
- R2: cmd_op 1 (branch) with at least one active lane true and at least one active lane false pushes a frame holding the current mask and the false lanes. In the next cycle active_mask equals active_mask AND cond.
- R3: A branch where every active lane agrees (cond AND active equals active, or equals zero) leaves active_mask unchanged and pushes nothing.
- R4: cmd_op 2 (else) with a frame held sets active_mask to the top frame's pending mask: the lanes that were active at the branch and had cond 0 (zero for a loop frame). The stack is not changed.
- R5: cmd_op 3 (join) with a frame held pops it and restores the saved enclosing mask in the next cycle.
- R6: cmd_op 4 (loop test) with no loop frame on top and a divergent cond pushes a loop frame that saves the current mask. active_mask becomes active_mask AND cond.
- R7: A loop test with a loop frame on top and at least one continuing lane sets active_mask to active_mask AND cond and pushes nothing.
- R8: A loop test with a loop frame on top and no continuing lane pops the frame and restores its saved mask. A uniform loop test with no loop frame on top changes nothing.
- R9: A push requested while 4 frames are held sets ovf_err for one cycle. Mask and stack are unchanged.
- R10: A join or else with no frame held sets udf_err for one cycle. The mask is unchanged.
- R11: cmd_op 0 and codes 5 to 7 change nothing.
- R12: Branches nested four deep unwind through joins back to each enclosing mask in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command: 0 none, 1 branch, 2 else, 3 join, 4 loop test |
| cond | input | 32 | Per-lane condition, bit i for lane i |
| active_mask | output | 32 | Registered lane enable mask |
| ovf_err | output | 1 | One-cycle flag: push refused, stack full |
| udf_err | output | 1 | One-cycle flag: else or join with empty stack |

## Verification
A wrong saved frame stays hidden until the matching else, join or final loop exit. At that point active_mask differs from the enclosing mask one cycle after the command. A depth counter that is off shows up as an error flag at the wrong time, or as a restore from the wrong frame, on the first push or pop at the boundary. Long random command streams mixed with fully nested and full-stack cases therefore compare the mask and both flags every cycle against a frame-stack model.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_BRANCH = 3'd1,
    OP_ELSE   = 3'd2,
    OP_JOIN   = 3'd3,
    OP_LOOP   = 3'd4
  } simt_op_e;
endpackage

// File: rtl/simt_div_stack.sv
module simt_div_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [LANES-1:0] wr_outer,
  input  logic [LANES-1:0] wr_pend,
  input  logic             wr_loop,
  output logic [LANES-1:0] rd_outer,
  output logic [LANES-1:0] rd_pend,
  output logic             rd_loop,
  output logic             empty,
  output logic             full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0]    cnt;
  logic [CW-1:0]    cnt_dec;
  logic [PW-1:0]    wr_idx;
  logic [PW-1:0]    top_idx;
  logic [LANES-1:0] outer_mem [DEPTH];
  logic [LANES-1:0] pend_mem  [DEPTH];
  logic             loop_mem  [DEPTH];

  assign cnt_dec = cnt - CW'(1);
  assign wr_idx  = cnt[PW-1:0];
  assign top_idx = cnt_dec[PW-1:0];
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (push) cnt <= cnt + CW'(1);
    else if (pop)  cnt <= cnt_dec;
  end

  // Storage has no reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push) begin
      outer_mem[wr_idx] <= wr_outer;
      pend_mem[wr_idx]  <= wr_pend;
      loop_mem[wr_idx]  <= wr_loop;
    end
  end

  assign rd_outer = outer_mem[top_idx];
  assign rd_pend  = pend_mem[top_idx];
  assign rd_loop  = loop_mem[top_idx];

  // R9
  push_room_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt != CW'(DEPTH)));
  // R10
  pop_data_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
  // R5
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/simt_div_next.sv
module simt_div_next
  import simt_div_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [2:0]       op,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] active,
  input  logic             empty,
  input  logic             full,
  input  logic [LANES-1:0] top_outer,
  input  logic [LANES-1:0] top_pend,
  input  logic             top_loop,
  output logic [LANES-1:0] nxt_active,
  output logic             push,
  output logic             pop,
  output logic [LANES-1:0] push_pend,
  output logic             push_loop,
  output logic             ovf,
  output logic             udf
);
  logic [LANES-1:0] tlanes;
  logic [LANES-1:0] flanes;
  logic             split;

  assign tlanes = active & cond;
  assign flanes = active & ~cond;
  assign split  = (tlanes != '0) && (flanes != '0);

  always_comb begin
    nxt_active = active;
    push       = 1'b0;
    pop        = 1'b0;
    push_pend  = flanes;
    push_loop  = 1'b0;
    ovf        = 1'b0;
    udf        = 1'b0;
    case (op)
      OP_BRANCH: begin
        if (split) begin
          if (full) ovf = 1'b1;
          else begin
            push       = 1'b1;
            nxt_active = tlanes;
          end
        end
      end
      OP_ELSE: begin
        if (empty) udf = 1'b1;
        else       nxt_active = top_pend;
      end
      OP_JOIN: begin
        if (empty) udf = 1'b1;
        else begin
          pop        = 1'b1;
          nxt_active = top_outer;
        end
      end
      OP_LOOP: begin
        if (!empty && top_loop) begin
          if (tlanes == '0) begin
            pop        = 1'b1;
            nxt_active = top_outer;
          end else begin
            nxt_active = tlanes;
          end
        end else if (split) begin
          if (full) ovf = 1'b1;
          else begin
            push       = 1'b1;
            push_loop  = 1'b1;
            push_pend  = '0;
            nxt_active = tlanes;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/simt_div_mask.sv
module simt_div_mask
  import simt_div_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd_op,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] active_mask,
  output logic             ovf_err,
  output logic             udf_err
);
  logic [LANES-1:0] nxt_active;
  logic [LANES-1:0] top_outer;
  logic [LANES-1:0] top_pend;
  logic [LANES-1:0] push_pend;
  logic             top_loop, push_loop;
  logic             push, pop, empty, full, ovf, udf;

  simt_div_next #(.LANES(LANES)) u_next (
    .op(cmd_op), .cond(cond), .active(active_mask),
    .empty(empty), .full(full),
    .top_outer(top_outer), .top_pend(top_pend), .top_loop(top_loop),
    .nxt_active(nxt_active), .push(push), .pop(pop),
    .push_pend(push_pend), .push_loop(push_loop),
    .ovf(ovf), .udf(udf)
  );

  simt_div_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wr_outer(active_mask), .wr_pend(push_pend), .wr_loop(push_loop),
    .rd_outer(top_outer), .rd_pend(top_pend), .rd_loop(top_loop),
    .empty(empty), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_mask <= '1;
      ovf_err     <= 1'b0;
      udf_err     <= 1'b0;
    end else begin
      active_mask <= nxt_active;
      ovf_err     <= ovf;
      udf_err     <= udf;
    end
  end

  // R3
  uniform_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_BRANCH && (((cond & active_mask) == active_mask) ||
     ((cond & active_mask) == '0))) |=> $stable(active_mask));
  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_err |-> $stable(active_mask));
  // R10
  udf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    udf_err |-> $stable(active_mask));
  // R1
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ovf_err && udf_err));
endmodule

// File: tb/simt_div_mask_bench.sv
module simt_div_mask_bench;
  localparam int LANES = 32;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       cmd_op = 3'd0;
  logic [LANES-1:0] cond = '0;
  logic [LANES-1:0] active_mask;
  logic             ovf_err, udf_err;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [LANES-1:0] m_act;
  logic [LANES-1:0] m_outer [DEPTH];
  logic [LANES-1:0] m_pend  [DEPTH];
  bit               m_loop  [DEPTH];
  int               m_cnt;
  bit               m_ovf, m_udf;
  string            m_tag;

  always #10 clk = ~clk;

  simt_div_mask #(.LANES(LANES), .DEPTH(DEPTH)) u_simt_div_mask (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cond(cond),
    .active_mask(active_mask), .ovf_err(ovf_err), .udf_err(udf_err)
  );

  task automatic model_reset();
    m_act = '1; m_cnt = 0; m_ovf = 0; m_udf = 0;
  endtask

  task automatic model_push(input logic [LANES-1:0] pend, input bit lp,
                            input logic [LANES-1:0] nxt, input string tg);
    if (m_cnt == DEPTH) begin
      m_ovf = 1; m_tag = "R9";
    end else begin
      m_outer[m_cnt] = m_act; m_pend[m_cnt] = pend; m_loop[m_cnt] = lp;
      m_cnt++; m_act = nxt; m_tag = tg;
    end
  endtask

  task automatic model_step(input logic [2:0] op, input logic [LANES-1:0] c);
    logic [LANES-1:0] t, f;
    t = m_act & c; f = m_act & ~c;
    m_ovf = 0; m_udf = 0; m_tag = "R11";
    case (op)
      3'd1: if (t != '0 && f != '0) model_push(f, 0, t, "R2");
            else m_tag = "R3";
      3'd2: if (m_cnt == 0) begin m_udf = 1; m_tag = "R10"; end
            else begin m_act = m_pend[m_cnt-1]; m_tag = "R4"; end
      3'd3: if (m_cnt == 0) begin m_udf = 1; m_tag = "R10"; end
            else begin m_cnt--; m_act = m_outer[m_cnt]; m_tag = "R5"; end
      3'd4: if (m_cnt > 0 && m_loop[m_cnt-1]) begin
              if (t == '0) begin m_cnt--; m_act = m_outer[m_cnt]; m_tag = "R8"; end
              else begin m_act = t; m_tag = "R7"; end
            end else if (t != '0 && f != '0) model_push('0, 1, t, "R6");
            else m_tag = "R8";
      default: ;
    endcase
  endtask

  task automatic compare(input string tg);
    vectors++;
    if (active_mask !== m_act || ovf_err !== m_ovf || udf_err !== m_udf) begin
      errors++;
      $display("FAIL %s: mask=%h ovf=%b udf=%b expected mask=%h ovf=%b udf=%b",
               tg, active_mask, ovf_err, udf_err, m_act, m_ovf, m_udf);
    end
  endtask

  task automatic lit(input string tg, input logic [LANES-1:0] exp_m);
    vectors++;
    if (active_mask !== exp_m) begin
      errors++;
      $display("FAIL %s: mask=%h expected %h", tg, active_mask, exp_m);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [LANES-1:0] c);
    cmd_op = op; cond = c;
    @(posedge clk);
    model_step(op, c);
    @(negedge clk);
    cmd_op = 3'd0;
    compare(m_tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1'b1; errors++;
        $display("FAIL watchdog: cycles=%0d expected < 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");                   // R1 mask held during reset
    rst = 1'b0;
    @(negedge clk);
    compare("R1");                   // R1 first cycle after reset
    step(3'd3, '0);                  // R1 / R10 join on empty stack
    // R2 / R4 / R5 basic if-else-join
    step(3'd1, 32'h0000_FFFF); lit("R2", 32'h0000_FFFF);
    step(3'd2, '0);            lit("R4", 32'hFFFF_0000);
    step(3'd3, '0);            lit("R5", 32'hFFFF_FFFF);
    // R3 uniform branches push nothing
    step(3'd1, '1);            lit("R3", 32'hFFFF_FFFF);
    step(3'd1, '0);            lit("R3", 32'hFFFF_FFFF);
    step(3'd3, '0);                  // R3 no frame was pushed
    step(3'd2, '0);                  // R10 else on empty
    // R12 / R9 four-deep nesting then overflow
    step(3'd1, 32'h00FF_FFFF);
    step(3'd1, 32'h0000_FFFF);
    step(3'd1, 32'h0000_00FF);
    step(3'd1, 32'h0000_000F);       lit("R12", 32'h0000_000F);
    step(3'd1, 32'h0000_0003);       // R9 overflow
    step(3'd3, '0);                  lit("R12", 32'h0000_00FF);
    step(3'd3, '0);                  lit("R12", 32'h0000_FFFF);
    step(3'd3, '0);                  lit("R12", 32'h00FF_FFFF);
    step(3'd3, '0);                  lit("R12", 32'hFFFF_FFFF);
    // R6 / R7 / R8 loop handling
    step(3'd4, '1);                  // R8 uniform continue, no frame
    step(3'd4, 32'h0000_00FF);       lit("R6", 32'h0000_00FF);
    step(3'd4, 32'hF000_000F);       lit("R7", 32'h0000_000F);
    step(3'd4, 32'hFFFF_FF00);       lit("R8", 32'hFFFF_FFFF);
    step(3'd3, '0);                  // R8 frame gone: underflow
    // R11 unused codes
    step(3'd5, 32'h1234_5678); step(3'd6, '0); step(3'd7, '1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(99);
      logic [2:0] op;
      logic [LANES-1:0] c;
      if (r < 25) op = 3'd1; else if (r < 40) op = 3'd2;
      else if (r < 65) op = 3'd3; else if (r < 88) op = 3'd4;
      else op = 3'($urandom_range(7));
      case ($urandom_range(3))
        0: c = '1;
        1: c = '0;
        default: c = $urandom();
      endcase
      step(op, c);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule